// File: doc/BRIEF.md
# Machine Cycle and Address Latch Enable Generator

This block sets the pace of a fast 8051-compatible core. It divides the oscillator clock into machine cycles and marks the last clock of each cycle with a one-clock enable strobe. It also produces the prescaled increment enables for the core's timers and shapes the address latch enable (ALE) output that an external address latch uses.

In normal operation a machine cycle lasts 4 oscillator clocks. Software can choose one of two low-power divider settings that stretch each cycle to 64 or 1024 clocks. A new setting waits for the next cycle boundary, so no cycle is ever cut short. ALE rises when a machine cycle starts and stays high for one and a half clocks. The fall is timed by a register on the falling clock edge.

Software can park ALE high to reduce emissions, except while an external memory access is in progress. The timer prescaler runs from the oscillator clock regardless of the divider setting. Each timer takes a tick every 12 clocks, or every 4 clocks when that timer's fast option is set.

Top module: `mcyc_ale_gen`

## Requirements
- R1: With `pmm_sel_i` = 2'b00 a machine cycle is 4 clocks long, and `mcyc_en_o` is high for exactly one clock per cycle, namely the last clock of the cycle.
- R2: `pmm_sel_i` = 2'b01 gives 64-clock machine cycles; 2'b10 and 2'b11 both give 1024-clock machine cycles.
- R3: A change of `pmm_sel_i` is taken only at the end of the clock in which `mcyc_en_o` is high. The cycle in progress keeps its old length, and the next cycle has the new length.
- R4: Unless ALE is parked, it rises at the rising edge that starts each machine cycle and falls at the falling edge in the middle of the cycle's second clock. It is therefore high for 3 of the 2×length half-clocks of every cycle, in every divider setting.
- R5: While `rst_ni` is low, `ale_o` is high and `mcyc_en_o` and `tmr_inc_o` are low. After release, the first machine cycle is a 4-clock cycle that includes the clock in which reset was released, whatever `pmm_sel_i` is.
- R6: With `ale_off_i` = 1 and `ext_acc_i` = 0, `ale_o` is held high for the whole cycle.
- R7: With `ext_acc_i` = 1, ALE pulses as in R4 whatever the value of `ale_off_i`.
- R8: A timer whose `tmr_fast_i` bit is 0 gets a one-clock `tmr_inc_o` pulse every 12 clocks. The first pulse comes in the 12th clock after reset release.
- R9: A timer whose `tmr_fast_i` bit is 1 gets a one-clock pulse every 4 clocks, with the first in the 4th clock after release. Each timer follows only its own bit, and the timer rate does not depend on `pmm_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pmm_sel_i | input | 2 | Divider setting: 00 normal, 01 64-clock, 1x 1024-clock |
| tmr_fast_i | input | NUM_TMR | Per-timer fast option (4-clock tick) |
| ale_off_i | input | 1 | Park ALE high when no external access is running |
| ext_acc_i | input | 1 | External memory access in progress |
| mcyc_en_o | output | 1 | High in the last clock of each machine cycle |
| tmr_inc_o | output | NUM_TMR | Per-timer increment enable |
| ale_o | output | 1 | Address latch enable |

## Verification
On every clock the assertions check the following: the cycle counter advances by one between boundaries, the enable strobe never lasts two clocks, the divider setting holds still inside a cycle, and ALE is high after a boundary and low again one clock later unless it is parked. They also check that a parked ALE stays high and that each prescaler tick is a single clock. Some behaviour can only be shown by the bench scenarios: the actual cycle lengths for each divider code, the half-clock ALE width seen on both clock edges, the exact cycle in which a mid-cycle setting change takes effect, and the tick counts per timer over fixed windows.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

  typedef enum logic [1:0] {
    MODE_NORM = 2'b00,
    MODE_PMM1 = 2'b01,
    MODE_PMM2 = 2'b10
  } mcyc_mode_e;

  function automatic mcyc_mode_e decode_mode(input logic [1:0] sel);
    case (sel)
      2'b00:   decode_mode = MODE_NORM;
      2'b01:   decode_mode = MODE_PMM1;
      default: decode_mode = MODE_PMM2;
    endcase
  endfunction

endpackage

// File: rtl/mcg_cycle_div.sv
module mcg_cycle_div
  import mcg_pkg::*;
#(
  parameter int NORM_LEN = 4,
  parameter int PMM1_LEN = 64,
  parameter int PMM2_LEN = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] pmm_sel_i,
  output logic       first_o,
  output logic       last_o
);

  localparam int CNT_W = $clog2(PMM2_LEN);
  localparam logic [CNT_W-1:0] NORM_LAST = CNT_W'(NORM_LEN - 1);
  localparam logic [CNT_W-1:0] PMM1_LAST = CNT_W'(PMM1_LEN - 1);
  localparam logic [CNT_W-1:0] PMM2_LAST = CNT_W'(PMM2_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;
  mcyc_mode_e       mode_q;

  always_comb begin
    case (mode_q)
      MODE_NORM: last_val = NORM_LAST;
      MODE_PMM1: last_val = PMM1_LAST;
      default:   last_val = PMM2_LAST;
    endcase
  end

  assign last_o  = (cnt_q == last_val);
  assign first_o = (cnt_q == '0);

  // mode is only sampled at the cycle boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= MODE_NORM;
    end else if (last_o) begin
      cnt_q  <= '0;
      mode_q <= decode_mode(pmm_sel_i);
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_o |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_en_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !last_o);

  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> first_o);

  p_mode_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_o |=> $stable(mode_q));

endmodule

// File: rtl/mcg_tmr_presc.sv
module mcg_tmr_presc #(
  parameter int NUM_TMR    = 3,
  parameter int FAST_DIV   = 4,
  parameter int LEGACY_DIV = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_TMR-1:0] tmr_fast_i,
  output logic [NUM_TMR-1:0] tmr_inc_o
);

  localparam int SLOW_MULT = LEGACY_DIV / FAST_DIV;
  localparam int FW = $clog2(FAST_DIV);
  localparam int SW = (SLOW_MULT > 1) ? $clog2(SLOW_MULT) : 1;
  localparam logic [FW-1:0] F_LAST = FW'(FAST_DIV - 1);
  localparam logic [SW-1:0] S_LAST = SW'(SLOW_MULT - 1);

  logic [FW-1:0] fast_q;
  logic [SW-1:0] slow_q;
  logic          fast_tick;
  logic          slow_tick;

  assign fast_tick = (fast_q == F_LAST);
  assign slow_tick = fast_tick && (slow_q == S_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_q <= '0;
      slow_q <= '0;
    end else begin
      fast_q <= fast_tick ? '0 : fast_q + 1'b1;
      if (fast_tick) slow_q <= slow_tick ? '0 : slow_q + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    assign tmr_inc_o[i] = tmr_fast_i[i] ? fast_tick : slow_tick;
  end

  p_fast_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_tick |=> !fast_tick);

  p_slow_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_tick |=> !slow_tick);

endmodule

// File: rtl/mcg_ale_shape.sv
module mcg_ale_shape (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic first_i,
  input  logic force_hi_i,
  output logic ale_o
);

  logic neg_q;

  // half-clock extension: captures first clock on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= first_i;
  end

  assign ale_o = ~rst_ni | force_hi_i | first_i | neg_q;

endmodule

// File: rtl/mcyc_ale_gen.sv
module mcyc_ale_gen #(
  parameter int NORM_LEN   = 4,
  parameter int PMM1_LEN   = 64,
  parameter int PMM2_LEN   = 1024,
  parameter int NUM_TMR    = 3,
  parameter int FAST_DIV   = 4,
  parameter int LEGACY_DIV = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         pmm_sel_i,
  input  logic [NUM_TMR-1:0] tmr_fast_i,
  input  logic               ale_off_i,
  input  logic               ext_acc_i,
  output logic               mcyc_en_o,
  output logic [NUM_TMR-1:0] tmr_inc_o,
  output logic               ale_o
);

  logic first_w;
  logic last_w;
  logic park_w;

  assign park_w    = ale_off_i & ~ext_acc_i;
  assign mcyc_en_o = last_w;

  mcg_cycle_div #(
    .NORM_LEN(NORM_LEN),
    .PMM1_LEN(PMM1_LEN),
    .PMM2_LEN(PMM2_LEN)
  ) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pmm_sel_i(pmm_sel_i),
    .first_o  (first_w),
    .last_o   (last_w)
  );

  mcg_tmr_presc #(
    .NUM_TMR   (NUM_TMR),
    .FAST_DIV  (FAST_DIV),
    .LEGACY_DIV(LEGACY_DIV)
  ) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tmr_fast_i(tmr_fast_i),
    .tmr_inc_o (tmr_inc_o)
  );

  mcg_ale_shape u_ale (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .first_i   (first_w),
    .force_hi_i(park_w),
    .ale_o     (ale_o)
  );

  p_ale_park_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_off_i && !ext_acc_i) |-> ale_o);

  p_ale_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcyc_en_o |=> ale_o);

  p_ale_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mcyc_en_o, 2) && !(ale_off_i && !ext_acc_i)) |-> !ale_o);

endmodule

// File: tb/tb_mcyc_ale_gen.sv
`timescale 1ns/1ps
module tb_mcyc_ale_gen;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] pmm_sel = 2'b00;
  logic [2:0] tmr_fast = 3'b000;
  logic       ale_off = 1'b0;
  logic       ext_acc = 1'b0;
  logic       mcyc_en;
  logic [2:0] tmr_inc;
  logic       ale;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  mcyc_ale_gen dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .pmm_sel_i (pmm_sel),
    .tmr_fast_i(tmr_fast),
    .ale_off_i (ale_off),
    .ext_acc_i (ext_acc),
    .mcyc_en_o (mcyc_en),
    .tmr_inc_o (tmr_inc),
    .ale_o     (ale)
  );

  // {pmm[1:0], ale_off, ext, pad, len[10:0]}
  localparam logic [15:0] VEC [8] = '{
    {2'b00, 1'b0, 1'b0, 1'b0, 11'd4},
    {2'b01, 1'b0, 1'b0, 1'b0, 11'd64},
    {2'b10, 1'b0, 1'b0, 1'b0, 11'd1024},
    {2'b11, 1'b0, 1'b0, 1'b0, 11'd1024},
    {2'b00, 1'b1, 1'b0, 1'b0, 11'd4},
    {2'b00, 1'b1, 1'b1, 1'b0, 11'd4},
    {2'b01, 1'b1, 1'b0, 1'b0, 11'd64},
    {2'b01, 1'b1, 1'b1, 1'b0, 11'd64}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // clocks until mcyc_en is seen, counting the current one if already high
  task automatic clocks_to_end(output int n);
    n = 0;
    while (!mcyc_en && n < 3000) begin
      tick();
      n++;
    end
  endtask

  // sync to a boundary, then measure one full cycle
  task automatic measure(output int len, output int halves);
    int dummy;
    clocks_to_end(dummy);
    len = 0;
    halves = 0;
    for (int k = 0; k < 3000; k++) begin
      tick();
      len++;
      if (ale) halves++;
      @(negedge clk); #1;
      if (ale) halves++;
      if (mcyc_en) break;
    end
  endtask

  task automatic count_tmr(input int n, output int c0, output int c1, output int c2);
    c0 = 0; c1 = 0; c2 = 0;
    for (int k = 0; k < n; k++) begin
      tick();
      c0 += int'(tmr_inc[0]);
      c1 += int'(tmr_inc[1]);
      c2 += int'(tmr_inc[2]);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_ni = 1'b0;
    #1;
    chk("R5 ale in reset", int'(ale), 1);
    chk("R5 mcyc_en in reset", int'(mcyc_en), 0);
    chk("R5 tmr_inc in reset", int'(tmr_inc), 0);
    repeat (3) tick();
    chk("R5 ale held in reset", int'(ale), 1);
    rst_ni = 1'b1;
  endtask

  initial begin : watchdog
    #(150000 * 5);
    n_err++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    int len, halves, n, c0, c1, c2, first0, first1;
    string tag;
    tmr_fast = 3'b010;
    do_reset();

    // R8 / R9: first ticks after release
    first0 = 0; first1 = 0;
    for (int k = 1; k <= 12; k++) begin
      tick();
      if (tmr_inc[1] && first1 == 0) first1 = k;
      if (tmr_inc[0] && first0 == 0) first0 = k;
    end
    chk("R9 first fast tick", first1, 3);
    chk("R8 first slow tick", first0, 11);

    // vector walk
    for (int v = 0; v < 8; v++) begin
      int exp_len, exp_half;
      pmm_sel = VEC[v][15:14];
      ale_off = VEC[v][13];
      ext_acc = VEC[v][12];
      exp_len = int'(VEC[v][10:0]);
      exp_half = (ale_off && !ext_acc) ? 2 * exp_len : 3;
      measure(len, halves);
      measure(len, halves);
      tag = (pmm_sel == 2'b00) ? "R1 cycle length" : "R2 cycle length";
      chk(tag, len, exp_len);
      tag = (ale_off && !ext_acc) ? "R6 ale halves" :
            (ale_off ? "R7 ale halves" : "R4 ale halves");
      chk(tag, halves, exp_half);
    end

    // R3: change during a 64-clock cycle
    ale_off = 1'b0; ext_acc = 1'b0;
    pmm_sel = 2'b01;
    measure(len, halves);
    clocks_to_end(n);
    repeat (10) tick();
    pmm_sel = 2'b00;
    clocks_to_end(n);
    chk("R3 old cycle kept", n, 54);
    tick();
    clocks_to_end(n);
    chk("R3 new length", n + 1, 4);

    // R3: change from normal to 64 at first clock of a cycle
    tick();
    clocks_to_end(n);
    pmm_sel = 2'b01;
    clocks_to_end(n);
    chk("R3 normal cycle kept", n, 0);
    measure(len, halves);
    chk("R3 switched length", len, 64);

    // R8 / R9: windows under normal and slow divider
    pmm_sel = 2'b00;
    tmr_fast = 3'b010;
    count_tmr(48, c0, c1, c2);
    chk("R8 slow count t0", c0, 4);
    chk("R9 fast count t1", c1, 12);
    chk("R8 slow count t2", c2, 4);
    pmm_sel = 2'b10;
    tmr_fast = 3'b101;
    count_tmr(48, c0, c1, c2);
    chk("R9 fast count t0 pmm", c0, 12);
    chk("R8 slow count t1 pmm", c1, 4);
    chk("R9 fast count t2 pmm", c2, 12);

    // R5: mid-run reset with slow setting still requested
    pmm_sel = 2'b01;
    do_reset();
    clocks_to_end(n);
    chk("R5 first cycle normal", n + 1, 4);
    measure(len, halves);
    chk("R5 then slow length", len, 64);
    chk("R4 ale halves pmm1", halves, 3);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule